// File: doc/BRIEF.md
# USB frame-start pulse generator

This block follows the 1 ms frame rhythm of a full-speed USB bus and raises a short output strobe slightly ahead of every frame boundary it expects. It advances an internal bit-time phase counter on a 12 MHz clock enable and snaps that counter back to zero each time the packet front end flags a received start-of-frame packet. From this phase it predicts the next frame start and opens a four-bit-time window ten bit times before it, so that external logic can prepare in time.

The strobe is held off until the timing is trustworthy. After a bus reset or a resume it appears only once two start-of-frame packets have been counted, and a suspend indication silences it at once. A software enable bit gates the pin. A status flag reports whether the tracker is locked. All pins are plain control and status levels or strobes, with no data stream and no handshake.

Top module: `usb_frame_pulse`

## Requirements
- R1: While `pulse_en` is 0, `sof_pulse` is 0.
- R2: Each pulse lasts exactly `PULSE_BITS` (default 4) cycles in which `bit_en` is 1.
- R3: With `bit_en` high every cycle, a pulse rises on the `FRAME_BITS - LEAD_BITS`th cycle after the clock edge that samples `sof_strobe`. The defaults are 12000 and 10, so the pulse begins 10 bit times before the next frame is due.
- R4: After reset, `bus_reset` or `resume`, no pulse is produced until two `sof_strobe` events have been accepted. The phase counter stays idle until the first one.
- R5: While `suspend` is 1, `sof_pulse` is 0 from the same cycle on, and lock is lost.
- R6: `locked` rises in the cycle after the second accepted `sof_strobe`. It falls in the cycle after any of `bus_reset`, `resume` or `suspend`.
- R7: Each `sof_strobe` reloads the phase to zero, so a late frame start shifts the next pulse to the new timing. With no new strobe, the counter wraps every `FRAME_BITS` bit times.
- R8: Clearing `pulse_en` during a pulse drops `sof_pulse` in the same cycle, and the rest of that pulse is discarded. It does not resume when the bit is set again.
- R9: A `sof_strobe` that arrives before the pulse point of its frame resynchronises the phase. That frame gives no pulse, and the next pulse comes one full lead-adjusted period after the new strobe, exactly once.
- R10: The phase and the pulse length advance only on cycles with `bit_en` high. At half rate, a pulse therefore lasts `2*PULSE_BITS` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle enable per full-speed bit time |
| sof_strobe | input | 1 | One-cycle flag: start-of-frame packet received |
| bus_reset | input | 1 | USB bus reset detected |
| resume | input | 1 | USB resume detected |
| suspend | input | 1 | USB suspend condition active (level) |
| pulse_en | input | 1 | Software enable for the output pulse |
| sof_pulse | output | 1 | Frame-start pulse pin |
| locked | output | 1 | Frame timer locked on two start-of-frame packets |

## Verification
The bound checker tests on every cycle that the pin stays quiet while disabled, suspended or unlocked, that lock always drops the cycle after a reset, resume or suspend, and that lock only rises right after an accepted strobe. The exact placement of the pulse relative to the strobe, its width in bit times, the effect of late and early strobes, the half-rate enable case and the discarding of a pulse interrupted by the enable bit all depend on counting across a frame. Only the bench's directed scenarios show these.

// File: rtl/ufp_pkg.sv
package ufp_pkg;
  localparam int FS_FRAME_BITS = 12000;
  localparam int FS_LEAD_BITS  = 10;
  localparam int FS_PULSE_BITS = 4;
  localparam int FS_LOCK_SOFS  = 2;

  typedef struct packed {
    logic clear;  // reset, resume or suspend: drop all timing state
    logic sof;    // start-of-frame accepted this cycle
  } ufp_evt_t;
endpackage

// File: rtl/ufp_lock_tracker.sv
module ufp_lock_tracker
  import ufp_pkg::*;
#(
  parameter int LOCK_SOFS = FS_LOCK_SOFS
) (
  input  logic     clk,
  input  logic     rst_n,
  input  ufp_evt_t evt,
  output logic     locked
);
  localparam int CNT_W = $clog2(LOCK_SOFS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LOCK_SOFS);

  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n || evt.clear) seen_q <= '0;
    else if (evt.sof && seen_q != FULL) seen_q <= seen_q + 1'b1;
  end

  assign locked = (seen_q == FULL);
endmodule

// File: rtl/ufp_frame_timer.sv
module ufp_frame_timer
  import ufp_pkg::*;
#(
  parameter int FRAME_BITS = FS_FRAME_BITS,
  parameter int LEAD_BITS  = FS_LEAD_BITS
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bit_en,
  input  ufp_evt_t evt,
  output logic     fire
);
  localparam int PH_W = $clog2(FRAME_BITS);
  localparam logic [PH_W-1:0] LAST    = PH_W'(FRAME_BITS - 1);
  localparam logic [PH_W-1:0] PRE_HIT = PH_W'(FRAME_BITS - LEAD_BITS - 1);

  logic [PH_W-1:0] phase_q;
  logic            running_q;

  always_ff @(posedge clk) begin
    if (!rst_n || evt.clear) begin
      phase_q   <= '0;
      running_q <= 1'b0;
    end else if (evt.sof) begin
      phase_q   <= '0;
      running_q <= 1'b1;
    end else if (running_q && bit_en) begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end

  // Step into the pulse point on this bit; a strobe in the same cycle wins.
  assign fire = running_q && bit_en && !evt.sof && !evt.clear && (phase_q == PRE_HIT);
endmodule

// File: rtl/ufp_pulse_shaper.sv
module ufp_pulse_shaper
  import ufp_pkg::*;
#(
  parameter int PULSE_BITS = FS_PULSE_BITS
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bit_en,
  input  ufp_evt_t evt,
  input  logic     fire,
  input  logic     locked,
  input  logic     pulse_en,
  input  logic     suspend,
  output logic     pulse
);
  localparam int LEN_W = $clog2(PULSE_BITS + 1);
  localparam logic [LEN_W-1:0] LEN = LEN_W'(PULSE_BITS);

  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n || evt.clear || !pulse_en) left_q <= '0;
    else if (fire && locked) left_q <= LEN;
    else if (bit_en && left_q != '0) left_q <= left_q - 1'b1;
  end

  assign pulse = (left_q != '0) && pulse_en && !suspend;
endmodule

// File: rtl/usb_frame_pulse.sv
module usb_frame_pulse
  import ufp_pkg::*;
#(
  parameter int FRAME_BITS = FS_FRAME_BITS,
  parameter int LEAD_BITS  = FS_LEAD_BITS,
  parameter int PULSE_BITS = FS_PULSE_BITS,
  parameter int LOCK_SOFS  = FS_LOCK_SOFS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic sof_strobe,
  input  logic bus_reset,
  input  logic resume,
  input  logic suspend,
  input  logic pulse_en,
  output logic sof_pulse,
  output logic locked
);
  ufp_evt_t evt;
  logic     fire;
  logic     lock_w;

  always_comb begin
    evt.clear = bus_reset || resume || suspend;
    evt.sof   = sof_strobe && !evt.clear;
  end

  ufp_lock_tracker #(.LOCK_SOFS(LOCK_SOFS)) u_lock (
    .clk(clk), .rst_n(rst_n), .evt(evt), .locked(lock_w)
  );

  ufp_frame_timer #(.FRAME_BITS(FRAME_BITS), .LEAD_BITS(LEAD_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .evt(evt), .fire(fire)
  );

  ufp_pulse_shaper #(.PULSE_BITS(PULSE_BITS)) u_shape (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .evt(evt), .fire(fire),
    .locked(lock_w), .pulse_en(pulse_en), .suspend(suspend), .pulse(sof_pulse)
  );

  assign locked = lock_w;
endmodule

// File: rtl/usb_frame_pulse_chk.sv
module usb_frame_pulse_chk (
  input logic clk,
  input logic rst_n,
  input logic sof_strobe,
  input logic bus_reset,
  input logic resume,
  input logic suspend,
  input logic pulse_en,
  input logic sof_pulse,
  input logic locked
);
  p_gate_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_en |-> !sof_pulse);

  p_unlocked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !sof_pulse);

  p_suspend_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> !sof_pulse);

  p_lock_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset || resume || suspend) |=> !locked);

  p_lock_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(sof_strobe));
endmodule

bind usb_frame_pulse usb_frame_pulse_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sof_strobe(sof_strobe), .bus_reset(bus_reset),
  .resume(resume), .suspend(suspend), .pulse_en(pulse_en),
  .sof_pulse(sof_pulse), .locked(locked)
);

// File: tb/tb_usb_frame_pulse.sv
module tb_usb_frame_pulse;
  localparam int FRAME = 100;
  localparam int LEAD  = 10;
  localparam int PLEN  = 4;
  localparam int HIT   = FRAME - LEAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b1;
  logic sof_strobe = 1'b0, bus_reset = 1'b0, resume = 1'b0, suspend = 1'b0;
  logic pulse_en = 1'b1;
  logic sof_pulse, locked;
  logic half_rate = 1'b0;
  int checks = 0, errors = 0;
  int first, cnt;

  always #5 clk = ~clk;
  always @(negedge clk) bit_en <= half_rate ? ~bit_en : 1'b1;

  usb_frame_pulse #(.FRAME_BITS(FRAME), .LEAD_BITS(LEAD), .PULSE_BITS(PLEN)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sof_strobe(sof_strobe),
    .bus_reset(bus_reset), .resume(resume), .suspend(suspend),
    .pulse_en(pulse_en), .sof_pulse(sof_pulse), .locked(locked)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Raise strobe at a negedge; returns at the negedge after the capturing edge.
  task automatic send_sof();
    sof_strobe = 1'b1;
    @(negedge clk);
    sof_strobe = 1'b0;
  endtask

  task automatic pulse_in(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  // Sample n cycles; index k is the state after k edges past the strobe edge.
  task automatic observe(input int n, output int f, output int c);
    f = -1; c = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (sof_pulse) begin
        if (f < 0) f = k;
        c++;
      end
    end
  endtask

  task automatic t_reset_state();
    check("R4 reset pulse", sof_pulse, 0);
    check("R6 reset locked", locked, 0);
  endtask

  task automatic t_lock_sequence();
    send_sof();
    check("R6 one sof not locked", locked, 0);
    observe(FRAME - 1, first, cnt);
    check("R4 no pulse after one sof", cnt, 0);
    send_sof();
    check("R6 locked after two sofs", locked, 1);
    observe(FRAME - 1, first, cnt);
    check("R3 pulse position", first, HIT);
    check("R2 pulse width", cnt, PLEN);
  endtask

  task automatic t_disabled();
    pulse_en = 1'b0;
    send_sof();
    observe(FRAME - 1, first, cnt);
    check("R1 disabled no pulse", cnt, 0);
    pulse_en = 1'b1;
  endtask

  task automatic t_cut_by_enable();
    send_sof();
    observe(HIT + 1, first, cnt);
    check("R8 pulse running", cnt, 2);
    pulse_en = 1'b0;
    #1;
    check("R8 drops same cycle", sof_pulse, 0);
    @(negedge clk);
    pulse_en = 1'b1;
    observe(FRAME - HIT - 3, first, cnt);
    check("R8 remainder discarded", cnt, 0);
  endtask

  task automatic t_late_sof();
    send_sof();
    observe(FRAME + 10, first, cnt);
    check("R7 one pulse before late sof", cnt, PLEN);
    send_sof();
    observe(FRAME - 1, first, cnt);
    check("R7 pulse follows late sof", first, HIT);
  endtask

  task automatic t_early_sof();
    send_sof();
    observe(50, first, cnt);
    check("R9 no pulse before early sof", cnt, 0);
    send_sof();
    observe(FRAME - 1, first, cnt);
    check("R9 single pulse after early sof", cnt, PLEN);
    check("R9 pulse position", first, HIT);
  endtask

  task automatic t_half_rate();
    half_rate = 1'b1;
    send_sof();
    observe(2 * FRAME - 2, first, cnt);
    check("R10 width in clocks", cnt, 2 * PLEN);
    checks++;
    if (first < 2 * HIT - 2 || first > 2 * HIT + 2) begin
      errors++;
      $display("FAIL R10 position: actual %0d expected about %0d", first, 2 * HIT);
    end
    half_rate = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_suspend();
    send_sof();
    observe(HIT + 1, first, cnt);
    suspend = 1'b1;
    #1;
    check("R5 suspend silences", sof_pulse, 0);
    @(negedge clk);
    check("R6 suspend unlocks", locked, 0);
    observe(20, first, cnt);
    check("R5 quiet during suspend", cnt, 0);
    suspend = 1'b0;
    pulse_in(resume);
    check("R6 resume unlocked", locked, 0);
    send_sof();
    observe(FRAME - 1, first, cnt);
    check("R4 no pulse one sof after resume", cnt, 0);
    send_sof();
    observe(FRAME - 1, first, cnt);
    check("R4 pulse after relock", first, HIT);
  endtask

  task automatic t_bus_reset();
    pulse_in(bus_reset);
    check("R6 bus reset unlocks", locked, 0);
    observe(2 * FRAME, first, cnt);
    check("R4 idle without sof", cnt, 0);
    send_sof();
    observe(FRAME - 1, first, cnt);
    check("R4 no pulse after reset and one sof", cnt, 0);
  endtask

  initial begin : watchdog
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_lock_sequence();
    t_disabled();
    t_cut_by_enable();
    t_late_sof();
    t_early_sof();
    t_half_rate();
    t_suspend();
    t_bus_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule